// File: doc/BRIEF.md
# Multi-Thread Stage Flow Controller with Skid Buffers

This block governs the flow of instruction tokens through one in-order pipeline stage that is shared by several hardware threads. Each cycle it receives a group of up to `IN_W` tokens from the stage above. Every token carries a tag, a thread number and a kill mark. The block forwards at most `OUT_W` tokens to the stage below. Threads share those output lanes in ascending thread order. Any token that cannot be forwarded is parked in a per-thread skid buffer.

Per thread, the block keeps a five-state controller and one sticky stall flag for each of three downstream stages. The three stages raise and release stalls with block and unblock requests. In return, the block sends single-cycle block and unblock pulses to the stage above. It also honours two squash inputs per thread. A commit squash flushes the thread. A rollback-in-progress input holds the thread in its squashing state.

The contents of the tokens are opaque to the block; only the flow of tokens is managed.

Top module: `skid_stage_ctrl`

## Requirements
- R1: After a synchronous reset, every thread is Idle and no stall flag is set. The state codes are Idle=0, Running=1, Blocked=2, Unblocking=3 and Squashing=4. After reset, all lanes, pulses and flags are low.
- R2: A Running or Idle thread forwards its live tokens in input-lane order, filling output lanes from lane 0 upward, with valid lanes contiguous. If tokens are left over, they go to the skid buffer, the thread becomes Blocked, and an upstream block pulse is raised.
- R3: The output lanes are shared. Thread 0 takes lanes first, each later thread gets only the lanes still free, and a thread that runs out of lanes blocks.
- R4: A token with its kill mark set is discarded without taking an output lane or skid entry. `drop_count` reports the number of such tokens in the current cycle.
- R5: A block request from any of the three downstream stages sets that stage's sticky flag for the thread. With any flag set, the thread parks its live tokens and enters Blocked. The block pulse is raised only when the thread was not already Blocked.
- R6: `stall_proto_err` is high in a cycle where an unblock request arrives for a flag that is clear and is not being set in the same cycle.
- R7: A Blocked thread with all flags clear resumes. With an empty skid buffer, it sends an unblock pulse and becomes Running in the same cycle. Otherwise it becomes Unblocking, drains up to the free lanes from its skid buffer, and appends live tokens behind the parked ones. Once the buffer is empty it sends an unblock pulse and becomes Running.
- R8: `stage_active` is high while the registered state of any thread is Unblocking.
- R9: A commit squash has top priority. The thread enters Squashing, its skid buffer and live tokens are discarded, and it forwards nothing. An unblock pulse is sent if the thread was Blocked or Unblocking.
- R10: A rollback-in-progress input, when there is no commit squash, keeps the thread in Squashing and discards its live tokens with no pulse. A Squashing thread with no squash and no stall becomes Running and forwards live tokens in the same cycle.
- R11: A thread that resumes with an empty skid buffer and then has tokens left over cancels its unblock pulse instead of raising a block pulse. Neither pulse is seen and the thread ends Blocked.
- R12: The skid buffer of each thread holds (`UP_DELAY`+1)×`IN_W` tokens. An insert beyond this capacity is dropped and raises `skid_overflow` for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | IN_W | Input lane valid |
| in_tag | input | IN_W×8 | Input token tags |
| in_tid | input | IN_W×TID_W | Thread number per input lane |
| in_kill | input | IN_W | Token already squashed, discard |
| ds_block | input | 3×NT | Block request per downstream stage and thread |
| ds_unblock | input | 3×NT | Unblock request per downstream stage and thread |
| commit_squash | input | NT | Commit squash per thread |
| rob_squashing | input | NT | Rollback still in progress per thread |
| out_valid | output | OUT_W | Output lane valid |
| out_tag | output | OUT_W×8 | Output token tags |
| out_tid | output | OUT_W×TID_W | Thread number per output lane |
| up_block | output | NT | Block pulse to the stage above |
| up_unblock | output | NT | Unblock pulse to the stage above |
| thread_state | output | NT×3 | Registered state per thread |
| stage_active | output | 1 | Some thread is Unblocking |
| skid_overflow | output | 1 | A skid insert exceeded capacity |
| stall_proto_err | output | 1 | Unblock request with clear flag |
| drop_count | output | clog2(IN_W+1) | Killed tokens this cycle |

## Verification
Directed groups are used first.
- Three tokens for one thread separate the plain width limit from spill-over into the skid buffer.
- A mixed-thread group whose higher thread sits in lane 0 shows whether lanes are granted by thread order rather than by lane order.
- A stall that parks more than two tokens forces a real Unblocking phase. A stall with an empty buffer followed by a wide group shows the pulse cancellation.
- Sustained input while stalled exposes the capacity limit.

A long seeded random run then mixes threads, kills, stalls and both squash kinds. Every output is compared against a queue-based reference model in each cycle.

// File: rtl/skid_ctl_pkg.sv
package skid_ctl_pkg;

    localparam int TAG_W  = 8;
    localparam int NUM_DS = 3;

    typedef logic [TAG_W-1:0] tag_t;

    typedef enum logic [2:0] {
        TS_IDLE    = 3'd0,
        TS_RUN     = 3'd1,
        TS_BLOCKED = 3'd2,
        TS_UNBLK   = 3'd3,
        TS_SQUASH  = 3'd4
    } tstate_e;

    function automatic int skid_cap(input int delay, input int up_w);
        return (delay + 1) * up_w;
    endfunction

    function automatic int min_i(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/stall_tracker.sv
module stall_tracker
    import skid_ctl_pkg::*;
#(
    parameter int NT = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_DS-1:0][NT-1:0]   blk,
    input  logic [NUM_DS-1:0][NT-1:0]   unblk,
    output logic [NT-1:0]               stalled,
    output logic                        proto_err
);
    logic [NUM_DS-1:0][NT-1:0] flag_q, flag_d;

    always_comb begin
        flag_d    = (flag_q | blk) & ~unblk;
        proto_err = |(unblk & ~(flag_q | blk));
        stalled   = '0;
        for (int s = 0; s < NUM_DS; s++) begin
            stalled = stalled | flag_d[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= flag_d;
    end
endmodule

// File: rtl/skid_thread.sv
module skid_thread
    import skid_ctl_pkg::*;
#(
    parameter int IN_W  = 3,
    parameter int OUT_W = 2,
    parameter int CAP   = 6,
    localparam int CW   = $clog2(OUT_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [IN_W-1:0]         live_vld,
    input  tag_t [IN_W-1:0]         live_tag,
    input  logic                    stalled,
    input  logic                    squash,
    input  logic                    rob_sq,
    input  logic [CW-1:0]           slots,
    output logic [CW-1:0]           send_n,
    output tag_t [OUT_W-1:0]        send_tag,
    output logic                    up_blk,
    output logic                    up_unblk,
    output logic                    ovf,
    output tstate_e                 state
);
    localparam int QW = $clog2(CAP + 1);

    tstate_e          st_q, st_d;
    tag_t [CAP-1:0]   skid_q, skid_d;
    logic [QW-1:0]    cnt_q, cnt_d;

    always_comb begin : ctrl
        tag_t [IN_W-1:0] lt;
        int      lc, c, n, app_from;
        logic    do_app, unb_path;
        tstate_e eff;

        lt = '0;
        lc = 0;
        for (int i = 0; i < IN_W; i++) begin
            if (live_vld[i]) begin
                lt[lc] = live_tag[i];
                lc++;
            end
        end

        skid_d   = skid_q;
        c        = int'(cnt_q);
        n        = 0;
        st_d     = st_q;
        eff      = st_q;
        send_tag = '0;
        up_blk   = 1'b0;
        up_unblk = 1'b0;
        ovf      = 1'b0;
        do_app   = 1'b0;
        app_from = 0;
        unb_path = 1'b0;

        if (squash) begin
            st_d     = TS_SQUASH;
            c        = 0;
            skid_d   = '0;
            up_unblk = (st_q == TS_BLOCKED) || (st_q == TS_UNBLK);
        end else if (rob_sq) begin
            st_d = TS_SQUASH;
        end else if (stalled) begin
            up_blk = (st_q != TS_BLOCKED);
            st_d   = TS_BLOCKED;
            do_app = 1'b1;
        end else begin
            if (st_q == TS_BLOCKED) begin
                if (c == 0) begin
                    up_unblk = 1'b1;
                    eff      = TS_RUN;
                end else begin
                    eff = TS_UNBLK;
                end
            end else if (st_q == TS_SQUASH) begin
                eff = TS_RUN;
            end
            st_d = eff;
            if (eff == TS_UNBLK) begin
                n = min_i(int'(slots), c);
                for (int j = 0; j < OUT_W; j++) begin
                    if (j < n) send_tag[j] = skid_q[j];
                end
                for (int j = 0; j < CAP; j++) begin
                    if (j + n < CAP) skid_d[j] = skid_q[j + n];
                    else             skid_d[j] = '0;
                end
                c        = c - n;
                do_app   = 1'b1;
                unb_path = 1'b1;
            end else begin
                n = min_i(int'(slots), lc);
                for (int j = 0; j < OUT_W; j++) begin
                    if (j < n) send_tag[j] = lt[j];
                end
                if (lc > n) begin
                    do_app   = 1'b1;
                    app_from = n;
                    st_d     = TS_BLOCKED;
                    if (up_unblk) up_unblk = 1'b0;
                    else          up_blk   = 1'b1;
                end
            end
        end

        if (do_app) begin
            for (int i = 0; i < IN_W; i++) begin
                if (i >= app_from && i < lc) begin
                    if (c < CAP) begin
                        skid_d[c] = lt[i];
                        c++;
                    end else begin
                        ovf = 1'b1;
                    end
                end
            end
        end

        if (unb_path && c == 0) begin
            up_unblk = 1'b1;
            st_d     = TS_RUN;
        end

        send_n = CW'(n);
        cnt_d  = QW'(c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= TS_IDLE;
            skid_q <= '0;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            skid_q <= skid_d;
            cnt_q  <= cnt_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/skid_stage_ctrl.sv
module skid_stage_ctrl
    import skid_ctl_pkg::*;
#(
    parameter int NT       = 2,
    parameter int IN_W     = 3,
    parameter int OUT_W    = 2,
    parameter int UP_DELAY = 1,
    localparam int TID_W   = (NT > 1) ? $clog2(NT) : 1,
    localparam int DW      = $clog2(IN_W + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [IN_W-1:0]                 in_valid,
    input  logic [IN_W-1:0][TAG_W-1:0]      in_tag,
    input  logic [IN_W-1:0][TID_W-1:0]      in_tid,
    input  logic [IN_W-1:0]                 in_kill,
    input  logic [NUM_DS-1:0][NT-1:0]       ds_block,
    input  logic [NUM_DS-1:0][NT-1:0]       ds_unblock,
    input  logic [NT-1:0]                   commit_squash,
    input  logic [NT-1:0]                   rob_squashing,
    output logic [OUT_W-1:0]                out_valid,
    output logic [OUT_W-1:0][TAG_W-1:0]     out_tag,
    output logic [OUT_W-1:0][TID_W-1:0]     out_tid,
    output logic [NT-1:0]                   up_block,
    output logic [NT-1:0]                   up_unblock,
    output logic [NT-1:0][2:0]              thread_state,
    output logic                            stage_active,
    output logic                            skid_overflow,
    output logic                            stall_proto_err,
    output logic [DW-1:0]                   drop_count
);
    localparam int CAP = skid_cap(UP_DELAY, IN_W);
    localparam int CW  = $clog2(OUT_W + 1);

    logic [NT-1:0]      stalled;
    logic [NT-1:0]      ov_v;
    logic [CW-1:0]      send_n   [NT];
    tag_t [OUT_W-1:0]   send_tag [NT];
    logic [CW-1:0]      used_acc [NT+1];
    tstate_e            st_v     [NT];

    stall_tracker #(.NT(NT)) u_stall (
        .clk       (clk),
        .rst       (rst),
        .blk       (ds_block),
        .unblk     (ds_unblock),
        .stalled   (stalled),
        .proto_err (stall_proto_err)
    );

    assign used_acc[0] = '0;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic [IN_W-1:0] lv;
        always_comb begin
            for (int i = 0; i < IN_W; i++) begin
                lv[i] = in_valid[i] & ~in_kill[i] & (in_tid[i] == TID_W'(t));
            end
        end

        skid_thread #(.IN_W(IN_W), .OUT_W(OUT_W), .CAP(CAP)) u_thr (
            .clk      (clk),
            .rst      (rst),
            .live_vld (lv),
            .live_tag (in_tag),
            .stalled  (stalled[t]),
            .squash   (commit_squash[t]),
            .rob_sq   (rob_squashing[t]),
            .slots    (CW'(OUT_W) - used_acc[t]),
            .send_n   (send_n[t]),
            .send_tag (send_tag[t]),
            .up_blk   (up_block[t]),
            .up_unblk (up_unblock[t]),
            .ovf      (ov_v[t]),
            .state    (st_v[t])
        );

        assign used_acc[t+1]   = used_acc[t] + send_n[t];
        assign thread_state[t] = st_v[t];
    end

    always_comb begin
        out_valid    = '0;
        out_tag      = '0;
        out_tid      = '0;
        stage_active = 1'b0;
        for (int t = 0; t < NT; t++) begin
            for (int j = 0; j < OUT_W; j++) begin
                if (j < int'(send_n[t]) && int'(used_acc[t]) + j < OUT_W) begin
                    out_valid[int'(used_acc[t]) + j] = 1'b1;
                    out_tag[int'(used_acc[t]) + j]   = send_tag[t][j];
                    out_tid[int'(used_acc[t]) + j]   = TID_W'(t);
                end
            end
            if (st_v[t] == TS_UNBLK) stage_active = 1'b1;
        end
    end

    always_comb begin
        drop_count = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (in_valid[i] && in_kill[i]) drop_count = drop_count + 1'b1;
        end
    end

    assign skid_overflow = |ov_v;
endmodule

// File: rtl/skid_stage_ctrl_chk.sv
module skid_stage_ctrl_chk #(
    parameter int NT    = 2,
    parameter int OUT_W = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NT-1:0]        commit_squash,
    input logic [OUT_W-1:0]     out_valid,
    input logic [NT-1:0]        up_block,
    input logic [NT-1:0]        up_unblock,
    input logic [NT-1:0][2:0]   thread_state
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (thread_state == '0));

    assert_lanes_packed_R2: assert property (@(posedge clk) disable iff (rst)
        ((out_valid & (out_valid + 1'b1)) == '0));

    assert_pulse_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        ((up_block & up_unblock) == '0));

    for (genvar t = 0; t < NT; t++) begin : g_t
        assert_block_enters_R5: assert property (@(posedge clk) disable iff (rst)
            up_block[t] |=> (thread_state[t] == 3'd2));

        assert_unblock_runs_R7: assert property (@(posedge clk) disable iff (rst)
            (up_unblock[t] && !commit_squash[t]) |=> (thread_state[t] == 3'd1));

        assert_squash_enters_R9: assert property (@(posedge clk) disable iff (rst)
            commit_squash[t] |=> (thread_state[t] == 3'd4));
    end
endmodule

bind skid_stage_ctrl skid_stage_ctrl_chk #(.NT(NT), .OUT_W(OUT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .commit_squash (commit_squash),
    .out_valid     (out_valid),
    .up_block      (up_block),
    .up_unblock    (up_unblock),
    .thread_state  (thread_state)
);

// File: tb/tb_skid_stage_ctrl.sv
`timescale 1ns/1ps
module tb_skid_stage_ctrl;
    localparam int NT = 2, IN_W = 3, OUT_W = 2, UP_DELAY = 1;
    localparam int CAP = (UP_DELAY + 1) * IN_W;
    localparam int TID_W = 1, DW = 2;

    logic clk = 1'b0, rst = 1'b1;
    always #10 clk = ~clk;

    logic [IN_W-1:0]            in_valid = '0, in_kill = '0;
    logic [IN_W-1:0][7:0]       in_tag = '0;
    logic [IN_W-1:0][TID_W-1:0] in_tid = '0;
    logic [2:0][NT-1:0]         ds_block = '0, ds_unblock = '0;
    logic [NT-1:0]              commit_squash = '0, rob_squashing = '0;
    logic [OUT_W-1:0]           out_valid;
    logic [OUT_W-1:0][7:0]      out_tag;
    logic [OUT_W-1:0][TID_W-1:0] out_tid;
    logic [NT-1:0]              up_block, up_unblock;
    logic [NT-1:0][2:0]         thread_state;
    logic                       stage_active, skid_overflow, stall_proto_err;
    logic [DW-1:0]              drop_count;

    skid_stage_ctrl #(.NT(NT), .IN_W(IN_W), .OUT_W(OUT_W), .UP_DELAY(UP_DELAY)) dut (.*);

    // staged stimulus, applied at the falling edge
    logic [IN_W-1:0]            s_valid, s_kill;
    logic [IN_W-1:0][7:0]       s_tag;
    logic [IN_W-1:0][TID_W-1:0] s_tid;
    logic [2:0][NT-1:0]         s_dsb, s_dsu;
    logic [NT-1:0]              s_csq, s_rob;
    int  next_tag = 1;
    int  n_checks = 0, n_fail = 0;
    bit  done = 0;
    string cur_req = "R1";

    // reference model
    int m_st[NT], n_st[NT];
    bit m_flag[3][NT], n_flag[3][NT];
    int m_sk[NT][$], n_sk[NT][$];
    int e_vld[OUT_W], e_tag[OUT_W], e_tid[OUT_W];
    int e_bk[NT], e_ub[NT];
    int e_ovf, e_err, e_drop, e_act, used;

    task automatic chk(bit ok, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic clr();
        s_valid = '0; s_kill = '0; s_tag = '0; s_tid = '0;
        s_dsb = '0; s_dsu = '0; s_csq = '0; s_rob = '0;
    endtask

    task automatic lane(int i, int t, bit k);
        s_valid[i] = 1'b1; s_tid[i] = TID_W'(t); s_kill[i] = k;
        s_tag[i] = 8'(next_tag); next_tag++;
    endtask

    task automatic emit(int tag, int t);
        e_vld[used] = 1; e_tag[used] = tag; e_tid[used] = t; used++;
    endtask

    task automatic push_cap(int t, int v);
        if (n_sk[t].size() < CAP) n_sk[t].push_back(v);
        else e_ovf = 1;
    endtask

    task automatic model_eval();
        used = 0; e_ovf = 0; e_err = 0; e_drop = 0; e_act = 0;
        for (int j = 0; j < OUT_W; j++) begin e_vld[j] = 0; e_tag[j] = 0; e_tid[j] = 0; end
        for (int i = 0; i < IN_W; i++) if (in_valid[i] && in_kill[i]) e_drop++;
        for (int t = 0; t < NT; t++) if (m_st[t] == 3) e_act = 1;
        for (int s = 0; s < 3; s++)
            for (int t = 0; t < NT; t++) begin
                if (ds_unblock[s][t] && !(m_flag[s][t] || ds_block[s][t])) e_err = 1;
                n_flag[s][t] = ds_unblock[s][t] ? 1'b0 : (m_flag[s][t] || ds_block[s][t]);
            end
        for (int t = 0; t < NT; t++) begin
            int live[$];
            int st, eff, k;
            bit stl;
            e_bk[t] = 0; e_ub[t] = 0;
            for (int i = 0; i < IN_W; i++)
                if (in_valid[i] && !in_kill[i] && int'(in_tid[i]) == t) live.push_back(int'(in_tag[i]));
            stl = n_flag[0][t] || n_flag[1][t] || n_flag[2][t];
            st = m_st[t]; n_st[t] = st; n_sk[t] = m_sk[t];
            if (commit_squash[t]) begin
                n_st[t] = 4; n_sk[t].delete();
                e_ub[t] = (st == 2 || st == 3) ? 1 : 0;
            end else if (rob_squashing[t]) begin
                n_st[t] = 4;
            end else if (stl) begin
                if (st != 2) e_bk[t] = 1;
                n_st[t] = 2;
                foreach (live[i]) push_cap(t, live[i]);
            end else begin
                eff = st;
                if (st == 2) begin
                    if (n_sk[t].size() == 0) begin e_ub[t] = 1; eff = 1; end
                    else eff = 3;
                end else if (st == 4) eff = 1;
                n_st[t] = eff;
                if (eff == 3) begin
                    while (used < OUT_W && n_sk[t].size() > 0) emit(n_sk[t].pop_front(), t);
                    foreach (live[i]) push_cap(t, live[i]);
                    if (n_sk[t].size() == 0) begin e_ub[t] = 1; n_st[t] = 1; end
                end else begin
                    k = 0;
                    while (k < live.size() && used < OUT_W) begin emit(live[k], t); k++; end
                    if (k < live.size()) begin
                        for (int i = k; i < live.size(); i++) push_cap(t, live[i]);
                        n_st[t] = 2;
                        if (e_ub[t] == 1) e_ub[t] = 0; else e_bk[t] = 1;
                    end
                end
            end
        end
    endtask

    task automatic model_commit();
        for (int t = 0; t < NT; t++) begin
            m_st[t] = n_st[t]; m_sk[t] = n_sk[t];
            for (int s = 0; s < 3; s++) m_flag[s][t] = n_flag[s][t];
        end
    endtask

    task automatic compare();
        for (int j = 0; j < OUT_W; j++) begin
            chk(int'(out_valid[j]) == e_vld[j], $sformatf("out_valid[%0d]", j), int'(out_valid[j]), e_vld[j]);
            if (e_vld[j] != 0) begin
                chk(int'(out_tag[j]) == e_tag[j], $sformatf("out_tag[%0d]", j), int'(out_tag[j]), e_tag[j]);
                chk(int'(out_tid[j]) == e_tid[j], $sformatf("out_tid[%0d]", j), int'(out_tid[j]), e_tid[j]);
            end
        end
        for (int t = 0; t < NT; t++) begin
            chk(int'(thread_state[t]) == m_st[t], $sformatf("state[%0d]", t), int'(thread_state[t]), m_st[t]);
            chk(int'(up_block[t]) == e_bk[t], $sformatf("up_block[%0d]", t), int'(up_block[t]), e_bk[t]);
            chk(int'(up_unblock[t]) == e_ub[t], $sformatf("up_unblock[%0d]", t), int'(up_unblock[t]), e_ub[t]);
        end
        chk(int'(stage_active) == e_act, "stage_active", int'(stage_active), e_act);
        chk(int'(skid_overflow) == e_ovf, "skid_overflow", int'(skid_overflow), e_ovf);
        chk(int'(stall_proto_err) == e_err, "stall_proto_err", int'(stall_proto_err), e_err);
        chk(int'(drop_count) == e_drop, "drop_count", int'(drop_count), e_drop);
    endtask

    task automatic step();
        @(negedge clk);
        in_valid = s_valid; in_kill = s_kill; in_tag = s_tag; in_tid = s_tid;
        ds_block = s_dsb; ds_unblock = s_dsu; commit_squash = s_csq; rob_squashing = s_rob;
        #5;
        model_eval();
        compare();
        model_commit();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        for (int t = 0; t < NT; t++) begin
            m_st[t] = 0; m_sk[t].delete();
            for (int s = 0; s < 3; s++) m_flag[s][t] = 0;
        end
        clr();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        cur_req = "R1"; clr(); step();
        // R2: three tokens for thread 0 exceed the width
        cur_req = "R2"; clr(); lane(0,0,0); lane(1,0,0); lane(2,0,0); step();
        clr(); step(); step();
        // R3: thread 1 in lane 0 still yields to thread 0
        cur_req = "R3"; clr(); lane(0,1,0); lane(1,0,0); lane(2,0,0); step();
        clr(); step(); step();
        // R4: killed tokens dropped
        cur_req = "R4"; clr(); lane(0,0,1); lane(1,0,0); lane(2,1,1); step();
        // R5: sticky stall, repeat input while blocked
        cur_req = "R5"; clr(); s_dsb[1][0] = 1; lane(0,0,0); lane(1,0,0); lane(2,0,0); step();
        clr(); lane(0,0,0); step();
        // R7 then R8: drain four parked tokens
        cur_req = "R7"; clr(); s_dsu[1][0] = 1; step();
        cur_req = "R8"; clr(); step(); step();
        // R6: unblock with clear flag
        cur_req = "R6"; clr(); s_dsu[0][1] = 1; step();
        // R11: resume with empty skid and overflowing input
        cur_req = "R11"; clr(); s_dsb[2][0] = 1; step();
        clr(); s_dsu[2][0] = 1; lane(0,0,0); lane(1,0,0); lane(2,0,0); step();
        clr(); step(); step();
        // R12: capacity limit
        cur_req = "R12"; clr(); s_dsb[0][0] = 1; lane(0,0,0); lane(1,0,0); lane(2,0,0); step();
        clr(); lane(0,0,0); lane(1,0,0); lane(2,0,0); step();
        clr(); lane(0,0,0); lane(1,0,0); lane(2,0,0); step();
        clr(); s_dsu[0][0] = 1; step();
        clr(); repeat (4) step();
        // R9: commit squash while blocked and while unblocking
        cur_req = "R9"; clr(); s_dsb[0][1] = 1; lane(0,1,0); lane(1,1,0); lane(2,1,0); step();
        clr(); s_csq[1] = 1; lane(0,1,0); step();
        clr(); s_dsb[0][1] = 1; lane(0,1,0); lane(1,1,0); lane(2,1,0); step();
        clr(); s_dsu[0][1] = 1; lane(0,1,0); lane(1,1,0); lane(2,1,0); step();
        clr(); s_csq[1] = 1; step();
        clr(); lane(0,1,0); step();
        // R10: rollback holds Squashing, then resumes
        cur_req = "R10"; clr(); s_rob[0] = 1; lane(0,0,0); lane(1,0,0); step();
        clr(); s_rob[0] = 1; step();
        clr(); lane(0,0,0); lane(1,0,0); step();

        // mixed random traffic
        cur_req = "R3";
        void'($urandom(32'd2024));
        for (int cyc = 0; cyc < 3000; cyc++) begin
            clr();
            for (int i = 0; i < IN_W; i++)
                if ($urandom_range(99) < 60) lane(i, int'($urandom_range(NT-1)), $urandom_range(99) < 10);
            for (int s = 0; s < 3; s++)
                for (int t = 0; t < NT; t++) begin
                    s_dsb[s][t] = ($urandom_range(99) < 4);
                    s_dsu[s][t] = m_flag[s][t] ? ($urandom_range(99) < 30) : ($urandom_range(999) < 5);
                end
            for (int t = 0; t < NT; t++) begin
                s_csq[t] = ($urandom_range(99) < 2);
                s_rob[t] = ($urandom_range(99) < 3);
            end
            step();
        end
        summary();
    end
endmodule